// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the state of a small bank of interrupt sources and decides when each source is offered to a presentation controller. Every source carries a configured priority, a target server number and a level-or-message flag. It also has a two-bit presentation state (P = presented, Q = queued), a resend flag and a masked-pending flag. Commands arrive on one valid/ready stream: a trigger, an end-of-interrupt, a level-line-low notice, or a resend scan. Each command carries a source index. Deliveries leave on a valid/ready request stream with the global source number (`BASE` + index), priority and server. The presenter answers on a response channel with accept or refuse, plus the number of any source that the accepted delivery displaced.

Back-pressure rules: `cmd_ready` is high only when no delivery sequence is running. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. Once `dlv_valid` is raised, it stays high and its fields stay fixed until the cycle where `dlv_ready` is high. After that the block waits for exactly one `rsp_valid` pulse. Configuration writes are plain pins and take effect on the next edge.

Top module: `irqsrc_ctrl`

## Requirements
- R1: After reset every source has the masked priority 8'hFF, level flag 0, P/Q = 00, and no resend or masked-pending flag. `cmd_ready` is 1 and `dlv_valid` and `resend_set` are 0. A trigger to an unconfigured source produces no delivery request.
- R2: P is bit 0 and Q is bit 1 of the P/Q state. For a message source, a trigger sets the new Q to the old P and the new P to 1. A delivery starts only when the result is Q=0, P=1.
- R3: On end-of-interrupt (op 1), a message source moves Q into P and clears Q. A level source keeps its P/Q. In either case the source is delivered again if P is 1 afterwards.
- R4: For a level source, a trigger (op 0) sets P and delivers only if P was 0. The line-low op (op 3) clears P for a level source and changes nothing for a message source. Neither op delivers anything when P was already set or was cleared.
- R5: A delivery attempt on a source whose priority is 8'hFF sends no request and sets masked-pending. A later configuration write of a non-masked priority turns masked-pending into a set resend flag.
- R6: When the presenter refuses a delivery, the source's resend flag is set. `resend_set` pulses for one cycle, with `resend_server` equal to the refused source's server.
- R7: A scan (op 2) visits the sources in ascending index order. It delivers only those whose resend flag is set and clears each flag before that delivery, so a second scan right after one whose deliveries were all accepted delivers nothing.
- R8: An accepted delivery whose displaced number lies in `BASE`..`BASE`+`NUM_SRC`-1 starts a new delivery of that source, without checking its resend flag. A displaced number of 0, of `IPI_NUM`, or outside this bank's range is ignored.
- R9: Only one delivery sequence runs at a time. `cmd_ready` stays 0 from command acceptance until the sequence ends. An unacknowledged request holds `dlv_valid`, `dlv_num` and `dlv_prio` unchanged.
- R10: `dlv_num` equals `BASE` plus the source index. `dlv_prio` and `dlv_server` are the source's configured priority and server.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken this cycle if valid |
| cmd_op | input | 2 | 0 trigger, 1 end-of-interrupt, 2 resend scan, 3 level line low |
| cmd_idx | input | SRC_W | Source index of the command |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | SRC_W | Source index to configure |
| cfg_prio | input | PRIO_W | Priority; all ones means masked |
| cfg_server | input | SRV_W | Target server |
| cfg_lsi | input | 1 | 1 for a level source, 0 for a message source |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Presenter takes the request |
| dlv_num | output | IRQ_W | Global source number |
| dlv_prio | output | PRIO_W | Priority of the request |
| dlv_server | output | SRV_W | Server of the request |
| rsp_valid | input | 1 | Presenter response valid |
| rsp_ok | input | 1 | 1 accepted, 0 refused |
| rsp_displaced | input | IRQ_W | Number displaced by an accepted delivery, 0 if none |
| resend_set | output | 1 | One-cycle pulse: set this unit's bit in the presenter resend map |
| resend_server | output | SRV_W | Server whose resend map bit is set |

## Verification
The embedded properties watch, on every cycle, the protocol shape. No source ever holds Q without P. A request never carries the masked priority and holds steady while stalled. A refusal is always followed by a resend-map pulse, and that pulse has no other cause. Whether the right source is delivered the right number of times can only be shown by the bench's scenarios. That covers coalescing of repeated triggers, redelivery after end-of-interrupt, level-line handling, the masked-to-resend conversion, scan ordering and flag clearing, and the chained delivery of displaced sources.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;
  typedef enum logic [1:0] {
    OP_TRIG = 2'd0,
    OP_EOI  = 2'd1,
    OP_SCAN = 2'd2,
    OP_LOW  = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EVAL = 2'd1,
    S_SEND = 2'd2,
    S_WAIT = 2'd3
  } seq_state_e;

  // Bit positions inside the two-bit presentation state
  localparam int PQ_P = 0;
  localparam int PQ_Q = 1;
endpackage

// File: rtl/irqsrc_pq.sv
module irqsrc_pq
  import irqsrc_pkg::*;
(
  input  cmd_op_e    op,
  input  logic       lsi,
  input  logic [1:0] pq_old,
  output logic [1:0] pq_new,
  output logic       fire
);
  always_comb begin
    pq_new = pq_old;
    fire   = 1'b0;
    unique case (op)
      OP_TRIG: begin
        if (lsi) begin
          pq_new       = pq_old;
          pq_new[PQ_P] = 1'b1;
          fire         = !pq_old[PQ_P];
        end else begin
          pq_new[PQ_Q] = pq_old[PQ_P];
          pq_new[PQ_P] = 1'b1;
          fire         = !pq_old[PQ_P];
        end
      end
      OP_EOI: begin
        if (!lsi) begin
          pq_new[PQ_P] = pq_old[PQ_Q];
          pq_new[PQ_Q] = 1'b0;
        end
        fire = lsi ? pq_old[PQ_P] : pq_old[PQ_Q];
      end
      OP_LOW: begin
        if (lsi) pq_new = 2'b00;
      end
      default: begin
        pq_new = pq_old;
      end
    endcase
  end
endmodule

// File: rtl/irqsrc_table.sv
module irqsrc_table #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int SRV_W   = 4,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SRC_W-1:0]  cfg_idx,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic              cfg_lsi,
  input  logic              pq_we,
  input  logic [SRC_W-1:0]  a_idx,
  input  logic [1:0]        pq_val,
  output logic              a_lsi,
  output logic [1:0]        a_pq,
  input  logic [SRC_W-1:0]  b_idx,
  input  logic              rs_clr,
  input  logic              rs_set,
  input  logic              mp_set,
  output logic [PRIO_W-1:0] b_prio,
  output logic [SRV_W-1:0]  b_server,
  output logic              b_resend
);
  localparam logic [PRIO_W-1:0] MASK = '1;

  logic [PRIO_W-1:0] prio_a [NUM_SRC];
  logic [SRV_W-1:0]  srv_a  [NUM_SRC];
  logic              lsi_a  [NUM_SRC];
  logic [1:0]        pq_a   [NUM_SRC];
  logic              rs_a   [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [PRIO_W-1:0] prio_r;
    logic [SRV_W-1:0]  srv_r;
    logic              lsi_r, rs_r, mp_r;
    logic [1:0]        pq_r;
    logic              cfg_hit, b_hit, unmask;

    assign cfg_hit = cfg_we && (cfg_idx == SRC_W'(i));
    assign b_hit   = (b_idx == SRC_W'(i));
    assign unmask  = cfg_hit && (cfg_prio != MASK) && (mp_r || (mp_set && b_hit));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_r <= MASK;
        srv_r  <= '0;
        lsi_r  <= 1'b0;
        pq_r   <= 2'b00;
        rs_r   <= 1'b0;
        mp_r   <= 1'b0;
      end else begin
        if (cfg_hit) begin
          prio_r <= cfg_prio;
          srv_r  <= cfg_server;
          lsi_r  <= cfg_lsi;
        end
        if (pq_we && (a_idx == SRC_W'(i))) pq_r <= pq_val;
        if ((rs_set && b_hit) || unmask) rs_r <= 1'b1;
        else if (rs_clr && b_hit)        rs_r <= 1'b0;
        if (unmask)                mp_r <= 1'b0;
        else if (mp_set && b_hit)  mp_r <= 1'b1;
      end
    end

    assign prio_a[i] = prio_r;
    assign srv_a[i]  = srv_r;
    assign lsi_a[i]  = lsi_r;
    assign pq_a[i]   = pq_r;
    assign rs_a[i]   = rs_r;

    AST_PQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      pq_r != 2'b10); // R2
  end

  assign a_lsi    = lsi_a[a_idx];
  assign a_pq     = pq_a[a_idx];
  assign b_prio   = prio_a[b_idx];
  assign b_server = srv_a[b_idx];
  assign b_resend = rs_a[b_idx];
endmodule

// File: rtl/irqsrc_seq.sv
module irqsrc_seq
  import irqsrc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int SRV_W   = 4,
  parameter int IRQ_W   = 12,
  parameter int BASE    = 16,
  parameter int IPI_NUM = 2,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  cmd_op_e           cmd_op,
  input  logic [SRC_W-1:0]  cmd_idx,
  input  logic              fire,
  output logic              pq_we,
  output logic [SRC_W-1:0]  cur_idx,
  input  logic [PRIO_W-1:0] b_prio,
  input  logic [SRV_W-1:0]  b_server,
  input  logic              b_resend,
  output logic              rs_clr,
  output logic              rs_set,
  output logic              mp_set,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [IRQ_W-1:0]  dlv_num,
  output logic [PRIO_W-1:0] dlv_prio,
  output logic [SRV_W-1:0]  dlv_server,
  input  logic              rsp_valid,
  input  logic              rsp_ok,
  input  logic [IRQ_W-1:0]  rsp_displaced,
  output logic              resend_set,
  output logic [SRV_W-1:0]  resend_server
);
  localparam logic [PRIO_W-1:0] MASK     = '1;
  localparam logic [SRC_W-1:0]  LAST_IDX = SRC_W'(NUM_SRC - 1);
  localparam logic [IRQ_W-1:0]  BASE_N   = IRQ_W'(BASE);
  localparam logic [IRQ_W-1:0]  IPI_N    = IRQ_W'(IPI_NUM);
  localparam logic [IRQ_W-1:0]  COUNT_N  = IRQ_W'(NUM_SRC);

  seq_state_e        state_q;
  logic [SRC_W-1:0]  cur_q, scan_idx_q;
  logic              chk_q, scan_q;
  logic [PRIO_W-1:0] prio_q;
  logic [SRV_W-1:0]  srv_q, mark_srv_q;
  logic              mark_q;

  logic              accept, skip, masked, refused, redo, finish;
  logic [IRQ_W-1:0]  disp_off;

  assign cmd_ready = (state_q == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign pq_we     = accept;

  assign skip    = (state_q == S_EVAL) && chk_q && !b_resend;
  assign masked  = (state_q == S_EVAL) && !skip && (b_prio == MASK);
  assign refused = (state_q == S_WAIT) && rsp_valid && !rsp_ok;

  assign disp_off = rsp_displaced - BASE_N;
  assign redo = (rsp_displaced != '0) && (rsp_displaced != IPI_N) &&
                (rsp_displaced >= BASE_N) && (disp_off < COUNT_N);

  assign finish = skip || masked ||
                  ((state_q == S_WAIT) && rsp_valid && !(rsp_ok && redo));

  assign rs_clr = (state_q == S_EVAL) && !skip;
  assign rs_set = refused;
  assign mp_set = masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cur_q      <= '0;
      scan_idx_q <= '0;
      chk_q      <= 1'b0;
      scan_q     <= 1'b0;
      prio_q     <= MASK;
      srv_q      <= '0;
      mark_q     <= 1'b0;
      mark_srv_q <= '0;
    end else begin
      mark_q <= refused;
      if (refused) mark_srv_q <= srv_q;
      if (finish) begin
        if (scan_q && (scan_idx_q != LAST_IDX)) begin
          scan_idx_q <= scan_idx_q + 1'b1;
          cur_q      <= scan_idx_q + 1'b1;
          chk_q      <= 1'b1;
          state_q    <= S_EVAL;
        end else begin
          scan_q  <= 1'b0;
          state_q <= S_IDLE;
        end
      end else begin
        unique case (state_q)
          S_IDLE: begin
            if (accept && cmd_op == OP_SCAN) begin
              scan_q     <= 1'b1;
              scan_idx_q <= '0;
              cur_q      <= '0;
              chk_q      <= 1'b1;
              state_q    <= S_EVAL;
            end else if (accept && fire) begin
              cur_q   <= cmd_idx;
              chk_q   <= 1'b0;
              state_q <= S_EVAL;
            end
          end
          S_EVAL: begin
            prio_q  <= b_prio;
            srv_q   <= b_server;
            state_q <= S_SEND;
          end
          S_SEND: begin
            if (dlv_ready) state_q <= S_WAIT;
          end
          S_WAIT: begin
            if (rsp_valid) begin
              cur_q   <= disp_off[SRC_W-1:0];
              chk_q   <= 1'b0;
              state_q <= S_EVAL;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign cur_idx       = cur_q;
  assign dlv_valid     = (state_q == S_SEND);
  assign dlv_num       = BASE_N + IRQ_W'(cur_q);
  assign dlv_prio      = prio_q;
  assign dlv_server    = srv_q;
  assign resend_set    = mark_q;
  assign resend_server = mark_srv_q;

  AST_NO_MASKED_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> dlv_prio != MASK); // R5
  AST_DLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_num) && $stable(dlv_prio)); // R9
  AST_SCAN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == OP_SCAN |=> !cmd_ready); // R9
  AST_REFUSE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT) && rsp_valid && !rsp_ok |=> resend_set); // R6
  AST_MARK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    resend_set |-> $past(rsp_valid && !rsp_ok)); // R6
endmodule

// File: rtl/irqsrc_ctrl.sv
module irqsrc_ctrl
  import irqsrc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int SRV_W   = 4,
  parameter int IRQ_W   = 12,
  parameter int BASE    = 16,
  parameter int IPI_NUM = 2,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [SRC_W-1:0]  cmd_idx,
  input  logic              cfg_we,
  input  logic [SRC_W-1:0]  cfg_idx,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic              cfg_lsi,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [IRQ_W-1:0]  dlv_num,
  output logic [PRIO_W-1:0] dlv_prio,
  output logic [SRV_W-1:0]  dlv_server,
  input  logic              rsp_valid,
  input  logic              rsp_ok,
  input  logic [IRQ_W-1:0]  rsp_displaced,
  output logic              resend_set,
  output logic [SRV_W-1:0]  resend_server
);
  cmd_op_e           op;
  logic              a_lsi, fire, pq_we, rs_clr, rs_set, mp_set, b_resend;
  logic [1:0]        a_pq, pq_new;
  logic [SRC_W-1:0]  cur_idx;
  logic [PRIO_W-1:0] b_prio;
  logic [SRV_W-1:0]  b_server;

  assign op = cmd_op_e'(cmd_op);

  irqsrc_pq u_pq (
    .op(op), .lsi(a_lsi), .pq_old(a_pq), .pq_new(pq_new), .fire(fire)
  );

  irqsrc_table #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SRV_W(SRV_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio),
    .cfg_server(cfg_server), .cfg_lsi(cfg_lsi),
    .pq_we(pq_we), .a_idx(cmd_idx), .pq_val(pq_new), .a_lsi(a_lsi), .a_pq(a_pq),
    .b_idx(cur_idx), .rs_clr(rs_clr), .rs_set(rs_set), .mp_set(mp_set),
    .b_prio(b_prio), .b_server(b_server), .b_resend(b_resend)
  );

  irqsrc_seq #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SRV_W(SRV_W), .IRQ_W(IRQ_W),
               .BASE(BASE), .IPI_NUM(IPI_NUM)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(op), .cmd_idx(cmd_idx),
    .fire(fire), .pq_we(pq_we), .cur_idx(cur_idx),
    .b_prio(b_prio), .b_server(b_server), .b_resend(b_resend),
    .rs_clr(rs_clr), .rs_set(rs_set), .mp_set(mp_set),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_num(dlv_num),
    .dlv_prio(dlv_prio), .dlv_server(dlv_server),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_displaced(rsp_displaced),
    .resend_set(resend_set), .resend_server(resend_server)
  );
endmodule

// File: tb/irqsrc_ctrl_test.sv
module irqsrc_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_ready;
  logic [1:0]  cmd_op = 0;
  logic [2:0]  cmd_idx = 0;
  logic        cfg_we = 0, cfg_lsi = 0;
  logic [2:0]  cfg_idx = 0;
  logic [7:0]  cfg_prio = 0;
  logic [3:0]  cfg_server = 0;
  logic        dlv_valid, dlv_ready = 0;
  logic [11:0] dlv_num;
  logic [7:0]  dlv_prio;
  logic [3:0]  dlv_server;
  logic        rsp_valid = 0, rsp_ok = 0;
  logic [11:0] rsp_displaced = 0;
  logic        resend_set;
  logic [3:0]  resend_server;

  int checks = 0, errors = 0, marks = 0;
  logic [3:0] last_mark_srv = 0;
  bit done = 0;

  irqsrc_ctrl uut (.*);

  always #2.5ns clk = ~clk;

  always @(negedge clk) if (resend_set) begin
    marks++;
    last_mark_srv = resend_server;
  end

  // {op, idx, expect delivery, accept}
  localparam logic [6:0] VEC [14] = '{
    {2'd0, 3'd0, 1'b1, 1'b1}, {2'd0, 3'd0, 1'b0, 1'b0}, {2'd0, 3'd0, 1'b0, 1'b0},
    {2'd1, 3'd0, 1'b1, 1'b1}, {2'd1, 3'd0, 1'b0, 1'b0}, {2'd0, 3'd0, 1'b1, 1'b1},
    {2'd1, 3'd0, 1'b0, 1'b0}, {2'd0, 3'd2, 1'b1, 1'b1}, {2'd0, 3'd2, 1'b0, 1'b0},
    {2'd1, 3'd2, 1'b1, 1'b1}, {2'd3, 3'd2, 1'b0, 1'b0}, {2'd1, 3'd2, 1'b0, 1'b0},
    {2'd3, 3'd0, 1'b0, 1'b0}, {2'd0, 3'd0, 1'b1, 1'b1}
  };

  function automatic logic [7:0] exp_prio(int i);
    case (i) 0: return 8'd5; 1: return 8'd7; 2: return 8'd4; 3: return 8'd9;
      4: return 8'd2; default: return 8'hFF; endcase
  endfunction

  function automatic logic [3:0] exp_srv(int i);
    return (i == 0) ? 4'd3 : 4'd1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg(int i, logic [7:0] p, logic [3:0] s, logic l);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(i); cfg_prio = p; cfg_server = s; cfg_lsi = l;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(logic [1:0] op, int i);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_idx = 3'(i);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic expect_dlv(int i, bit ok, int disp, string req);
    int n = 0;
    while (!dlv_valid && n < 30) begin @(negedge clk); n++; end
    check(dlv_valid, req, "request seen", int'(dlv_valid), 1);
    check(dlv_num == 12'(16 + i), req, "dlv_num", int'(dlv_num), 16 + i);
    check(dlv_prio == exp_prio(i), "R10", "dlv_prio", int'(dlv_prio), int'(exp_prio(i)));
    check(dlv_server == exp_srv(i), "R10", "dlv_server", int'(dlv_server), int'(exp_srv(i)));
    check(!cmd_ready, "R9", "cmd_ready while busy", int'(cmd_ready), 0);
    @(negedge clk); @(negedge clk);
    check(dlv_valid && dlv_num == 12'(16 + i), "R9", "held request", int'(dlv_num), 16 + i);
    dlv_ready = 1;
    @(negedge clk);
    dlv_ready = 0;
    @(negedge clk);
    rsp_valid = 1; rsp_ok = ok; rsp_displaced = 12'(disp);
    @(negedge clk);
    rsp_valid = 0; rsp_displaced = 0;
  endtask

  task automatic expect_none(string req);
    bit seen = 0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (dlv_valid) seen = 1;
    end
    check(!seen, req, "no request", int'(seen), 0);
    check(cmd_ready, req, "idle after", int'(cmd_ready), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int m;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cmd_ready == 1, "R1", "cmd_ready after reset", int'(cmd_ready), 1);
    check(dlv_valid == 0 && resend_set == 0, "R1", "outputs after reset",
          int'(dlv_valid), 0);
    send(2'd0, 5);
    expect_none("R1");

    cfg(0, 8'd5, 4'd3, 1'b0);
    cfg(1, 8'd7, 4'd1, 1'b0);
    cfg(2, 8'd4, 4'd1, 1'b1);
    cfg(4, 8'd2, 4'd1, 1'b0);

    // R2 R3 R4 table walk
    for (int v = 0; v < 14; v++) begin
      send(VEC[v][6:5], int'(VEC[v][4:2]));
      if (VEC[v][1]) expect_dlv(int'(VEC[v][4:2]), VEC[v][0], 0, "R2");
      else expect_none("R3");
    end
    send(2'd1, 0);
    expect_none("R3");

    // R5 masked source then unmask
    send(2'd0, 3);
    expect_none("R5");
    send(2'd2, 0);
    expect_none("R5");
    cfg(3, 8'd9, 4'd1, 1'b0);
    send(2'd2, 0);
    expect_dlv(3, 1, 0, "R5");
    send(2'd1, 3);
    expect_none("R5");

    // R6 refusal, R7 scan and clear
    m = marks;
    send(2'd0, 1);
    expect_dlv(1, 0, 0, "R6");
    @(negedge clk); @(negedge clk);
    check(marks == m + 1, "R6", "resend pulses", marks, m + 1);
    check(last_mark_srv == 4'd1, "R6", "resend_server", int'(last_mark_srv), 1);
    send(2'd2, 0);
    expect_dlv(1, 1, 0, "R7");
    send(2'd2, 0);
    expect_none("R7");
    send(2'd1, 1);
    expect_none("R7");

    // R7 scan order
    send(2'd0, 1);
    expect_dlv(1, 0, 0, "R6");
    send(2'd0, 0);
    expect_dlv(0, 0, 0, "R6");
    send(2'd2, 0);
    expect_dlv(0, 1, 0, "R7");
    expect_dlv(1, 1, 0, "R7");
    expect_none("R7");
    send(2'd1, 0);
    expect_none("R3");
    send(2'd1, 1);
    expect_none("R3");

    // R8 displaced sources
    send(2'd0, 0);
    expect_dlv(0, 1, 20, "R8");
    expect_dlv(4, 1, 0, "R8");
    expect_none("R8");
    send(2'd1, 0);
    expect_none("R8");
    send(2'd0, 1);
    expect_dlv(1, 1, 2, "R8");
    expect_none("R8");
    send(2'd1, 1);
    expect_none("R8");
    send(2'd0, 1);
    expect_dlv(1, 1, 100, "R8");
    expect_none("R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule